// File: doc/BRIEF.md
# Full/Empty Tagged Synchronizing Memory

This block is a small word-addressed storage array in which every word has a one-bit occupancy tag. A producer that writes in synchronized mode succeeds only if the word's tag is empty, and the tag becomes full in the same clock edge that stores the data. A consumer that reads in synchronized mode succeeds only if the tag is full, and the tag becomes empty in the edge that captures the data. A value therefore passes from one producer to one consumer with no separate lock or flag. The tag is checked and updated in the same edge as the data, so no other access can come between the check and the update.

There is one write port and one read port. Each port has a valid input and a ready output. Ready is a combinational function of the addressed word's current tag and of the access mode, and it does not depend on valid. When ready is low, a request that is presented is refused and has no effect. The requester may hold the request until ready rises, or drop it and treat the refusal as a failure. Each port also has a plain-mode bit. A plain access ignores the tag and does not change it, which suits initialisation and debug. Read data and its valid flag are registered and appear one cycle after the read is accepted.

Top module: `fe_sync_mem`

## Requirements
- R1: After synchronous reset, every tag is empty. A synchronized read of any address then sees rd_ready low, and a synchronized write sees wr_ready high.
- R2: A synchronized write (wr_plain=0) to a word whose tag is empty has wr_ready high. When wr_valid is high at the clock edge, the edge stores wr_data and sets the tag to full.
- R3: A synchronized write to a word whose tag is full has wr_ready low. Both the stored data and the tag stay unchanged.
- R4: A synchronized read (rd_plain=0) of a full word has rd_ready high. When rd_valid is high at the edge, the stored data is returned and the tag becomes empty.
- R5: A synchronized read of an empty word has rd_ready low. It produces no response, and the tag stays unchanged.
- R6: rd_resp_valid is high in exactly the cycle after a read is accepted (rd_valid and rd_ready both high at an edge), and low otherwise. In that cycle, rd_resp_data holds the word's value from before that edge.
- R7: When both ports address the same word in one cycle, the read uses the tag and data from before the write. A synchronized pair on an empty word accepts only the write. A synchronized pair on a full word accepts only the read. A value is never forwarded from the write to the read in the same cycle.
- R8: A plain write (wr_plain=1) is always accepted (wr_ready high). It stores the data and leaves the tag unchanged.
- R9: A plain read (rd_plain=1) is always accepted (rd_ready high). It returns the stored data with the R6 timing and leaves the tag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request present |
| wr_plain | input | 1 | 1 = plain write, ignores the tag; 0 = synchronized write |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| wr_ready | output | 1 | Write would be accepted this cycle |
| rd_valid | input | 1 | Read request present |
| rd_plain | input | 1 | 1 = plain read, ignores the tag; 0 = synchronized read |
| rd_addr | input | ADDR_W | Read word address |
| rd_ready | output | 1 | Read would be accepted this cycle |
| rd_resp_valid | output | 1 | Registered: a read was accepted in the previous cycle |
| rd_resp_data | output | DATA_W | Registered read data |

## Verification
The bench builds the block with DATA_W=8 and ADDR_W=3. With only eight words, every address can be swept in each phase: fill, refused overwrite, drain, refused re-read, and the same-address collisions in both tag states. Data values are computed from the address, so a wrong word or a wrong edge shows as a mismatch. A small bench model of the tag and data arrays predicts ready, response valid and response data for every cycle. With eight words, the sweeps also cover the lowest and highest addresses of the decode.

// File: rtl/fe_pkg.sv
package fe_pkg;

    typedef enum logic {
        ACC_SYNC  = 1'b0,
        ACC_PLAIN = 1'b1
    } acc_mode_e;

    // Per-edge tag update command
    typedef struct packed {
        logic set_en;
        logic clr_en;
    } tag_cmd_t;

    // Port may proceed: a plain access always may; a synced one needs the
    // tag in the wanted state (full for read, empty for write).
    function automatic logic port_ok(acc_mode_e mode, logic tag, logic want_full);
        return (mode == ACC_PLAIN) || (tag == want_full);
    endfunction

endpackage

// File: rtl/fe_tag_array.sv
module fe_tag_array #(
    parameter int WORDS  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  fe_pkg::tag_cmd_t  cmd,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic [ADDR_W-1:0] clr_addr,
    output logic [WORDS-1:0]  tags
);
    for (genvar i = 0; i < WORDS; i++) begin : g_tag
        always_ff @(posedge clk) begin
            if (rst)
                tags[i] <= 1'b0;
            else if (cmd.set_en && (set_addr == ADDR_W'(i)))
                tags[i] <= 1'b1;
            else if (cmd.clr_en && (clr_addr == ADDR_W'(i)))
                tags[i] <= 1'b0;
        end
    end

    // R1: the first cycle out of reset sees every tag empty
    a_r1_tags_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tags == '0));

endmodule

// File: rtl/fe_data_array.sv
module fe_data_array #(
    parameter int WORDS  = 16,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [WORDS];

    always_ff @(posedge clk) begin
        if (we)
            store[waddr] <= wdata;
    end

    // Combinational read of pre-edge contents; registered in the read stage
    assign rdata = store[raddr];

endmodule

// File: rtl/fe_read_stage.sv
module fe_read_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [DATA_W-1:0] din,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_data  <= '0;
        end else begin
            resp_valid <= fire;
            if (fire)
                resp_data <= din;
        end
    end

    // R6: a response follows an accepted read by exactly one cycle
    a_r6_resp_after_fire: assert property (@(posedge clk) disable iff (rst)
        fire |=> resp_valid);
    a_r6_no_resp_without_fire: assert property (@(posedge clk) disable iff (rst)
        !fire |=> !resp_valid);

endmodule

// File: rtl/fe_sync_mem.sv
module fe_sync_mem #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic              wr_plain,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              rd_valid,
    input  logic              rd_plain,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ready,
    output logic              rd_resp_valid,
    output logic [DATA_W-1:0] rd_resp_data
);
    import fe_pkg::*;

    localparam int WORDS = 1 << ADDR_W;

    logic [WORDS-1:0]  tags;
    logic [DATA_W-1:0] rd_word;
    acc_mode_e         wr_mode, rd_mode;
    logic              wr_fire, rd_fire;
    tag_cmd_t          tcmd;

    assign wr_mode = acc_mode_e'(wr_plain);
    assign rd_mode = acc_mode_e'(rd_plain);

    // Both ports look at the pre-edge tag: no same-cycle forwarding
    assign wr_ready = port_ok(wr_mode, tags[wr_addr], 1'b0);
    assign rd_ready = port_ok(rd_mode, tags[rd_addr], 1'b1);
    assign wr_fire  = wr_valid && wr_ready;
    assign rd_fire  = rd_valid && rd_ready;

    always_comb begin
        tcmd.set_en = wr_fire && (wr_mode == ACC_SYNC);
        tcmd.clr_en = rd_fire && (rd_mode == ACC_SYNC);
    end

    fe_tag_array #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .cmd      (tcmd),
        .set_addr (wr_addr),
        .clr_addr (rd_addr),
        .tags     (tags)
    );

    fe_data_array #(.WORDS(WORDS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
        .clk   (clk),
        .we    (wr_fire),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_word)
    );

    fe_read_stage #(.DATA_W(DATA_W)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .fire       (rd_fire),
        .din        (rd_word),
        .resp_valid (rd_resp_valid),
        .resp_data  (rd_resp_data)
    );

    // R2: an accepted synced write leaves its word full
    a_r2_write_sets_full: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_plain && wr_ready) |=> tags[$past(wr_addr)]);

    // R3: a synced write is never accepted into a full word
    a_r3_full_blocks_write: assert property (@(posedge clk) disable iff (rst)
        (!wr_plain && tags[wr_addr]) |-> !wr_ready);

    // R4: an accepted synced read leaves its word empty
    a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_plain && rd_ready) |=> !tags[$past(rd_addr)]);

    // R5: a synced read is never accepted from an empty word
    a_r5_empty_blocks_read: assert property (@(posedge clk) disable iff (rst)
        (!rd_plain && !tags[rd_addr]) |-> !rd_ready);

    // R7: synced read and write never both fire on one word in one cycle
    a_r7_no_passthrough: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && rd_valid && !wr_plain && !rd_plain && (wr_addr == rd_addr))
            |-> !(wr_ready && rd_ready));

    // R8/R9: cycles with only plain activity leave every tag as it was
    a_r8_r9_plain_keeps_tags: assert property (@(posedge clk) disable iff (rst)
        (!(wr_valid && !wr_plain) && !(rd_valid && !rd_plain)) |=> $stable(tags));

endmodule

// File: tb/fe_sync_mem_tb.sv
module fe_sync_mem_tb;
    localparam int DW = 8;
    localparam int AW = 3;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_valid, wr_plain, wr_ready;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          rd_valid, rd_plain, rd_ready;
    logic [AW-1:0] rd_addr;
    logic          rd_resp_valid;
    logic [DW-1:0] rd_resp_data;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic          m_tag [NW];
    logic [DW-1:0] m_mem [NW];

    always #5 clk = ~clk;

    fe_sync_mem #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_plain(wr_plain), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_valid(rd_valid), .rd_plain(rd_plain), .rd_addr(rd_addr),
        .rd_ready(rd_ready), .rd_resp_valid(rd_resp_valid),
        .rd_resp_data(rd_resp_data)
    );

    task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check readies, update model at edge,
    // then check the registered response after the edge.
    task automatic step(string req, bit wv, bit wp, logic [AW-1:0] wa, logic [DW-1:0] wd,
                        bit rv, bit rp, logic [AW-1:0] ra);
        bit ewr, err, wf, rf;
        logic [DW-1:0] edata;
        @(negedge clk);
        wr_valid = wv; wr_plain = wp; wr_addr = wa; wr_data = wd;
        rd_valid = rv; rd_plain = rp; rd_addr = ra;
        #1;
        ewr = wp || !m_tag[wa];
        err = rp || m_tag[ra];
        if (wv) chk(req, "wr_ready", DW'(wr_ready), DW'(ewr));
        if (rv) chk(req, "rd_ready", DW'(rd_ready), DW'(err));
        wf = wv && ewr;
        rf = rv && err;
        edata = m_mem[ra];
        @(posedge clk);
        if (rf && !rp) m_tag[ra] = 1'b0;
        if (wf) begin
            m_mem[wa] = wd;
            if (!wp) m_tag[wa] = 1'b1;
        end
        #1;
        chk(req, "rd_resp_valid (R6)", DW'(rd_resp_valid), DW'(rf));
        if (rf) chk(req, "rd_resp_data (R6)", rd_resp_data, edata);
    endtask

    function automatic logic [DW-1:0] pat(int a, int k);
        return DW'(a * 37 + k * 11 + 5);
    endfunction

    initial begin
        rst = 1'b1;
        wr_valid = 0; wr_plain = 0; wr_addr = '0; wr_data = '0;
        rd_valid = 0; rd_plain = 0; rd_addr = '0;
        for (int i = 0; i < NW; i++) begin m_tag[i] = 0; m_mem[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1", "rd_resp_valid after reset", DW'(rd_resp_valid), 0);

        // R1: all tags empty: synced reads refused, synced writes allowed
        for (int a = 0; a < NW; a++) begin
            @(negedge clk);
            wr_valid = 0; rd_valid = 0; wr_plain = 0; rd_plain = 0;
            wr_addr = AW'(a); rd_addr = AW'(a);
            #1;
            chk("R1", "rd_ready after reset", DW'(rd_ready), 0);
            chk("R1", "wr_ready after reset", DW'(wr_ready), 1);
        end

        // R2: fill every word
        for (int a = 0; a < NW; a++) step("R2", 1, 0, AW'(a), pat(a, 0), 0, 0, '0);
        // R3: overwrite attempts refused
        for (int a = 0; a < NW; a++) step("R3", 1, 0, AW'(a), pat(a, 1), 0, 0, '0);
        // R4: drain every word, original data expected
        for (int a = 0; a < NW; a++) step("R4", 0, 0, '0, '0, 1, 0, AW'(a));
        // R5: re-reading empty words is refused, no response
        for (int a = 0; a < NW; a++) step("R5", 0, 0, '0, '0, 1, 0, AW'(a));

        // R7: same-address collisions in both tag states
        for (int a = 0; a < NW; a++) begin
            step("R7", 1, 0, AW'(a), pat(a, 2), 1, 0, AW'(a)); // empty: write only
            step("R7", 1, 0, AW'(a), pat(a, 3), 1, 0, AW'(a)); // full: read only
            step("R7", 1, 0, AW'(a), pat(a, 4), 0, 0, '0);     // refill
            step("R7", 1, 1, AW'(a), pat(a, 5), 1, 0, AW'(a)); // plain wr + sync rd: old data
            step("R7", 0, 0, '0, '0, 1, 0, AW'(a));            // now empty: refused
        end

        // R8: plain writes into empty words keep them empty
        for (int a = 0; a < NW; a++) step("R8", 1, 1, AW'(a), pat(a, 6), 1, 0, AW'(a ^ 1));
        // R9: plain reads return data, tag still empty afterwards
        for (int a = 0; a < NW; a++) begin
            step("R9", 0, 0, '0, '0, 1, 1, AW'(a));
            step("R9", 0, 0, '0, '0, 1, 0, AW'(a));
        end
        // R8: plain write into full word keeps it full with new data
        for (int a = 0; a < NW; a++) begin
            step("R8", 1, 0, AW'(a), pat(a, 7), 0, 0, '0);
            step("R8", 1, 1, AW'(a), pat(a, 8), 1, 1, AW'(a));
            step("R8", 0, 0, '0, '0, 1, 0, AW'(a));
        end
        // Different-address concurrent synced traffic
        for (int a = 0; a < NW; a++) step("R2", 1, 0, AW'(a), pat(a, 9), 1, 0, AW'(a + 7));
        for (int a = 0; a < NW; a++) step("R4", 1, 0, AW'(a + 3), pat(a, 10), 1, 0, AW'(a));

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule